// File: doc/BRIEF.md
# Two-Queue Two-Core Instruction Dispatcher

This block moves instructions from two instruction queues onto two execution cores. Each queue presents its head instruction with a valid/ready handshake. The block pulls at most one instruction per queue into a one-entry holding slot. It then dispatches held instructions to idle cores, at most one dispatch per clock. Each queue has an enable and a two-bit core-eligibility mask. A shared two-bit code selects fixed priority for either queue or alternating service.

The cores are modelled as fixed-latency stubs inside the block. Each core reports whether it is busy. It also reports the queue number, payload and per-queue sequence index of the instruction it is running, or of the last one it ran, and a count of the instructions it has completed. The index of an instruction is its position within its own queue's dispatch stream.

Top module: `disp_arbiter`

## Requirements
- R1: After reset no core is busy, every core count, index and queue field is zero, and `inReady` equals `cfgEnable`.
- R2: `inReady[q]` is high exactly when queue q is enabled and its holding slot is empty; a disabled queue is never fetched from, while an instruction it already holds may still be dispatched.
- R3: A queue whose core mask is 2'b00 is never dispatched, and an instruction it has fetched stays held, which keeps its `inReady` low.
- R4: Bit 0 of a queue's mask allows core 0 to serve that queue and bit 1 allows core 1; a core never starts an instruction from a queue whose mask bit for that core was clear.
- R5: With `cfgPri` = 2'b01, queue 0 wins whenever both queues are dispatchable; with 2'b10, queue 1 wins.
- R6: With `cfgPri` = 2'b00 or 2'b11 and both queues dispatchable, the queue that did not receive the previous grant wins.
- R7: At most one instruction is dispatched per cycle, and the chosen queue goes to the lowest-numbered idle core its mask allows.
- R8: A dispatched core is busy from the cycle after the grant for exactly EXEC_LAT cycles; while busy and after it goes idle, it reports the instruction's queue id (0 or 1) and payload.
- R9: Each queue numbers its dispatched instructions 0, 1, 2, and so on, and the core reports that index.
- R10: A core's completed count rises by one on the clock edge at which its busy flag falls, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 2 | Head instruction valid, bit q for queue q |
| inData | input | 2 x DATA_W | Head instruction payload per queue |
| inReady | output | 2 | Holding slot accepts, bit q for queue q |
| cfgEnable | input | 2 | Per-queue fetch enable |
| cfgMask0 | input | 2 | Cores allowed to serve queue 0 |
| cfgMask1 | input | 2 | Cores allowed to serve queue 1 |
| cfgPri | input | 2 | 01: queue 0 first, 10: queue 1 first, 00/11: alternate |
| coreBusy | output | 2 | Core is executing |
| coreQid | output | 2 | Queue id of the current or last instruction per core |
| coreIid | output | 2 x IDX_W | Per-queue index of the current or last instruction per core |
| coreData | output | 2 x DATA_W | Payload of the current or last instruction per core |
| coreCount | output | 2 x CNT_W | Instructions completed per core |

## Verification
The dispatcher is driven with one queue alone, with one queue disabled, with one queue's mask cleared, and with disjoint masks. It is also run with both queues saturated on a single shared core under each priority code, and finally drained. The single-queue pattern shows the core-0-first choice and the starting index. The disabled and zero-mask patterns tell a stalled fetch from a stalled dispatch. The saturated single-core runs separate fixed priority from alternation, because only under that contention does the winner depend on the code. A behavioural model computes every port each cycle, so index, payload and count errors show up in every pattern.

// File: rtl/disp_pkg.sv
package disp_pkg;
  // Strobes from the arbitration control to the datapath and cores.
  typedef struct packed {
    logic [1:0] fetch;     // load holding slot q
    logic       grant;     // one dispatch this cycle
    logic       grantQ;    // queue being dispatched
    logic       grantCore; // core receiving it
  } dispStrobes_t;
endpackage

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import disp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   inValid,
  input  logic [1:0]   cfgEnable,
  input  logic [1:0]   cfgMask0,
  input  logic [1:0]   cfgMask1,
  input  logic [1:0]   cfgPri,
  input  logic [1:0]   held,
  input  logic [1:0]   coreBusy,
  output logic [1:0]   inReady,
  output dispStrobes_t strobes
);
  logic       lastWin;
  logic [1:0] avail0, avail1, availSel, elig;
  logic       pickQ;

  always_comb begin
    inReady = cfgEnable & ~held;
    avail0  = cfgMask0 & ~coreBusy;
    avail1  = cfgMask1 & ~coreBusy;
    elig    = {held[1] && (|avail1), held[0] && (|avail0)};
    unique case (cfgPri)
      2'b01:   pickQ = !elig[0];
      2'b10:   pickQ = elig[1];
      default: pickQ = (elig[0] && elig[1]) ? !lastWin : elig[1];
    endcase
    availSel          = pickQ ? avail1 : avail0;
    strobes.fetch     = inReady & inValid;
    strobes.grant     = |elig;
    strobes.grantQ    = pickQ;
    strobes.grantCore = !availSel[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lastWin <= 1'b1;
    else if (strobes.grant) lastWin <= strobes.grantQ;
  end
endmodule

// File: rtl/disp_dp.sv
module disp_dp
  import disp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dispStrobes_t           strobes,
  input  logic [1:0][DATA_W-1:0] inData,
  output logic [1:0]             held,
  output logic [DATA_W-1:0]      dispData,
  output logic [IDX_W-1:0]       dispIdx
);
  logic [1:0][DATA_W-1:0] slotData;
  logic [1:0][IDX_W-1:0]  nextIdx;

  for (genvar q = 0; q < 2; q++) begin : g_slot
    logic takeQ;
    assign takeQ = strobes.grant && (strobes.grantQ == q[0]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        held[q]     <= 1'b0;
        slotData[q] <= '0;
        nextIdx[q]  <= '0;
      end else begin
        if (strobes.fetch[q]) begin
          held[q]     <= 1'b1;
          slotData[q] <= inData[q];
        end else if (takeQ) begin
          held[q] <= 1'b0;
        end
        if (takeQ) nextIdx[q] <= nextIdx[q] + 1'b1;
      end
    end
  end

  assign dispData = slotData[strobes.grantQ];
  assign dispIdx  = nextIdx[strobes.grantQ];
endmodule

// File: rtl/disp_core_stub.sv
module disp_core_stub #(
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 32,
  parameter int CNT_W    = 32,
  parameter int EXEC_LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              qidIn,
  input  logic [IDX_W-1:0]  iidIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              busy,
  output logic              qidOut,
  output logic [IDX_W-1:0]  iidOut,
  output logic [DATA_W-1:0] dataOut,
  output logic [CNT_W-1:0]  count
);
  localparam int TMR_W = $clog2(EXEC_LAT + 1);
  logic [TMR_W-1:0] timer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      timer   <= '0;
      qidOut  <= 1'b0;
      iidOut  <= '0;
      dataOut <= '0;
      count   <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      timer   <= TMR_W'(EXEC_LAT - 1);
      qidOut  <= qidIn;
      iidOut  <= iidIn;
      dataOut <= dataIn;
    end else if (busy) begin
      if (timer == '0) begin
        busy  <= 1'b0;
        count <= count + 1'b1;
      end else begin
        timer <= timer - 1'b1;
      end
    end
  end
endmodule

// File: rtl/disp_arbiter.sv
module disp_arbiter
  import disp_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 32,
  parameter int CNT_W    = 32,
  parameter int EXEC_LAT = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             inValid,
  input  logic [1:0][DATA_W-1:0] inData,
  output logic [1:0]             inReady,
  input  logic [1:0]             cfgEnable,
  input  logic [1:0]             cfgMask0,
  input  logic [1:0]             cfgMask1,
  input  logic [1:0]             cfgPri,
  output logic [1:0]             coreBusy,
  output logic [1:0]             coreQid,
  output logic [1:0][IDX_W-1:0]  coreIid,
  output logic [1:0][DATA_W-1:0] coreData,
  output logic [1:0][CNT_W-1:0]  coreCount
);
  dispStrobes_t      strobes;
  logic [1:0]        held;
  logic [DATA_W-1:0] dispData;
  logic [IDX_W-1:0]  dispIdx;

  disp_ctrl i_ctrl (
    .clk, .rstN, .inValid, .cfgEnable, .cfgMask0, .cfgMask1, .cfgPri,
    .held, .coreBusy, .inReady, .strobes
  );

  disp_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_dp (
    .clk, .rstN, .strobes, .inData, .held, .dispData, .dispIdx
  );

  for (genvar c = 0; c < 2; c++) begin : g_core
    disp_core_stub #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .EXEC_LAT(EXEC_LAT)
    ) i_core (
      .clk, .rstN,
      .start  (strobes.grant && (strobes.grantCore == c[0])),
      .qidIn  (strobes.grantQ),
      .iidIn  (dispIdx),
      .dataIn (dispData),
      .busy   (coreBusy[c]),
      .qidOut (coreQid[c]),
      .iidOut (coreIid[c]),
      .dataOut(coreData[c]),
      .count  (coreCount[c])
    );
  end
endmodule

// File: rtl/disp_arbiter_chk.sv
module disp_arbiter_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 32,
  parameter int CNT_W  = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [1:0]             inReady,
  input logic [1:0]             cfgEnable,
  input logic [1:0]             cfgMask0,
  input logic [1:0]             cfgMask1,
  input logic [1:0]             coreBusy,
  input logic [1:0]             coreQid,
  input logic [1:0][IDX_W-1:0]  coreIid,
  input logic [1:0][CNT_W-1:0]  coreCount
);
  AST_DISABLED_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (inReady & ~cfgEnable) == 2'b00); // R2

  AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rstN)
    !($rose(coreBusy[0]) && $rose(coreBusy[1]))); // R7

  for (genvar c = 0; c < 2; c++) begin : g_chk
    AST_MASK_ALLOWS: assert property (@(posedge clk) disable iff (!rstN)
      $rose(coreBusy[c]) |-> (coreQid[c] ? $past(cfgMask1[c]) : $past(cfgMask0[c]))); // R4

    AST_INFO_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (coreBusy[c] && $past(coreBusy[c])) |-> ($stable(coreIid[c]) && $stable(coreQid[c]))); // R8

    AST_COUNT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
      $fell(coreBusy[c]) |-> (coreCount[c] == $past(coreCount[c]) + 1'b1)); // R10

    AST_COUNT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(coreCount[c]) |-> $fell(coreBusy[c])); // R10
  end
endmodule

bind disp_arbiter disp_arbiter_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_disp_arbiter.sv
module test_disp_arbiter;
  localparam int DW = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] inValid = '0, cfgEnable = 2'b11, cfgMask0 = 2'b11, cfgMask1 = 2'b11, cfgPri = '0;
  logic [1:0][DW-1:0] inData = '0;
  logic [1:0] inReady, coreBusy, coreQid;
  logic [1:0][31:0] coreIid, coreCount;
  logic [1:0][DW-1:0] coreData;

  always #4 clk = ~clk; // 125 MHz

  disp_arbiter #(.DATA_W(DW), .EXEC_LAT(LAT)) i_disp_arbiter (.*);

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit mHeld[2]; int mSlot[2]; int mIdx[2]; int mLast;
  bit mBusy[2]; int mTmr[2]; int mQid[2]; int mIid[2]; int mDat[2]; int mCnt[2];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLast = 1;
      for (int i = 0; i < 2; i++) begin
        mHeld[i] = 0; mSlot[i] = 0; mIdx[i] = 0;
        mBusy[i] = 0; mTmr[i] = 0; mQid[i] = 0; mIid[i] = 0; mDat[i] = 0; mCnt[i] = 0;
      end
    end else begin
      bit fet[2]; bit ok[2]; int q; int c; bit any;
      int allow[2];
      allow[0] = cfgMask0; allow[1] = cfgMask1;
      for (int i = 0; i < 2; i++) begin
        fet[i] = cfgEnable[i] && !mHeld[i] && inValid[i];
        ok[i]  = mHeld[i] && (((allow[i][0] && !mBusy[0])) || ((allow[i][1] && !mBusy[1])));
      end
      any = ok[0] || ok[1];
      if (ok[0] && ok[1]) begin
        if (cfgPri == 2'b01) q = 0;
        else if (cfgPri == 2'b10) q = 1;
        else q = 1 - mLast;
      end else q = ok[1] ? 1 : 0;
      c = (allow[q][0] && !mBusy[0]) ? 0 : 1;
      for (int i = 0; i < 2; i++)
        if (mBusy[i]) begin
          if (mTmr[i] == 0) begin mBusy[i] = 0; mCnt[i]++; end
          else mTmr[i]--;
        end
      if (any) begin
        mHeld[q] = 0; mBusy[c] = 1; mTmr[c] = LAT - 1;
        mQid[c] = q; mIid[c] = mIdx[q]; mDat[c] = mSlot[q];
        mIdx[q]++; mLast = q;
      end
      for (int i = 0; i < 2; i++)
        if (fet[i]) begin mHeld[i] = 1; mSlot[i] = inData[i]; end
    end
  end

  // Per-cycle comparison and start monitor
  bit prevBusy[2];
  int startsQ[2], totalStarts, crossViol, dualRise, firstCore, firstIid;
  always @(negedge clk) begin
    if (rstN) begin
      bit r[2];
      for (int i = 0; i < 2; i++) begin
        chk(inReady[i] == (cfgEnable[i] && !mHeld[i]), "R2 ready", inReady[i], cfgEnable[i] && !mHeld[i]);
        chk(coreBusy[i] == mBusy[i], "R8 busy", coreBusy[i], mBusy[i]);
        chk(coreQid[i] == mQid[i][0], "R8 qid", coreQid[i], mQid[i]);
        chk(coreData[i] == mDat[i][DW-1:0], "R8 data", coreData[i], mDat[i]);
        chk(coreIid[i] == mIid[i], "R9 index", coreIid[i], mIid[i]);
        chk(coreCount[i] == mCnt[i], "R10 count", coreCount[i], mCnt[i]);
        r[i] = coreBusy[i] && !prevBusy[i];
        if (r[i]) begin
          startsQ[coreQid[i]]++; totalStarts++;
          if (firstCore < 0) begin firstCore = i; firstIid = coreIid[i]; end
          if (coreQid[i] == 1'b0 && !cfgMask0[i]) crossViol++;
          if (coreQid[i] == 1'b1 && !cfgMask1[i]) crossViol++;
        end
        prevBusy[i] = coreBusy[i];
      end
      if (r[0] && r[1]) dualRise++;
    end
  end

  task automatic phase(input logic [1:0] en, m0, m1, pri, vld, input int n);
    @(posedge clk); #1;
    cfgEnable = en; cfgMask0 = m0; cfgMask1 = m1; cfgPri = pri; inValid = vld;
    repeat (2) begin @(posedge clk); #1; inData[0] += 16'h0011; inData[1] += 16'h0101; end
    startsQ[0] = 0; startsQ[1] = 0;
    repeat (n) begin @(posedge clk); #1; inData[0] += 16'h0011; inData[1] += 16'h0101; end
    @(negedge clk);
  endtask

  initial begin
    firstCore = -1;
    inData[0] = 16'h1000; inData[1] = 16'h2000;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(coreBusy == 2'b00, "R1 busy", coreBusy, 0);
    chk(coreCount[0] == 0 && coreCount[1] == 0, "R1 count", coreCount[0] + coreCount[1], 0);
    chk(coreIid[0] == 0 && coreQid == 2'b00, "R1 fields", coreIid[0], 0);
    chk(inReady == 2'b11, "R1 ready", inReady, 3);

    phase(2'b11, 2'b11, 2'b11, 2'b00, 2'b01, 12);
    chk(firstCore == 0, "R7 first core", firstCore, 0);
    chk(firstIid == 0, "R9 first index", firstIid, 0);

    phase(2'b01, 2'b11, 2'b11, 2'b00, 2'b11, 30);
    chk(startsQ[1] == 0, "R2 disabled queue starts", startsQ[1], 0);
    chk(inReady[1] == 1'b0, "R2 disabled ready", inReady[1], 0);

    phase(2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 30);
    chk(startsQ[1] == 0, "R3 zero mask starts", startsQ[1], 0);
    chk(inReady[1] == 1'b0, "R3 zero mask held", inReady[1], 0);
    chk(startsQ[0] > 0, "R3 other queue runs", startsQ[0], 1);

    phase(2'b11, 2'b01, 2'b10, 2'b00, 2'b11, 40);
    chk(crossViol == 0, "R4 mask cores", crossViol, 0);
    chk(startsQ[1] > 0, "R4 queue 1 on core 1", startsQ[1], 1);

    phase(2'b11, 2'b01, 2'b01, 2'b01, 2'b11, 40);
    chk(startsQ[1] == 0 && startsQ[0] > 0, "R5 queue 0 priority", startsQ[1], 0);

    phase(2'b11, 2'b01, 2'b01, 2'b10, 2'b11, 40);
    chk(startsQ[0] == 0 && startsQ[1] > 0, "R5 queue 1 priority", startsQ[0], 0);

    phase(2'b11, 2'b01, 2'b01, 2'b11, 2'b11, 40);
    chk(startsQ[0] > 0 && startsQ[1] > 0 && (startsQ[0] - startsQ[1]) <= 1 && (startsQ[1] - startsQ[0]) <= 1,
        "R6 alternate code 11", startsQ[0] - startsQ[1], 0);

    phase(2'b11, 2'b01, 2'b01, 2'b00, 2'b11, 40);
    chk(startsQ[0] > 0 && startsQ[1] > 0 && (startsQ[0] - startsQ[1]) <= 1 && (startsQ[1] - startsQ[0]) <= 1,
        "R6 alternate code 00", startsQ[0] - startsQ[1], 0);

    phase(2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 20);
    chk(dualRise == 0, "R7 one dispatch per cycle", dualRise, 0);
    chk(coreBusy == 2'b00, "R8 drained idle", coreBusy, 0);
    chk(coreCount[0] + coreCount[1] == totalStarts, "R10 completed total",
        coreCount[0] + coreCount[1], totalStarts);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); end
    join_any
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule